// File: doc/BRIEF.md
# Multichannel DMA Control Register Bank

This block is the register file that software uses to steer a multichannel DMA layer. It sits on a single-cycle register bus: a 10-bit register number, a write strobe, a read strobe, 32-bit write data and registered 32-bit read data. It holds global configuration, an error status word and an interrupt enable word. It also holds channel activation words for the transmit and receive sides, four per-channel event status words, one descriptor table pointer per channel and one buffer size per receive channel.

The DMA engine, which is not part of this block, reports events through one-cycle pulse inputs. These are end-of-buffer and descriptor error per channel, plus a word of error flags. Each pulse sets a sticky status bit, and software clears the bit by writing a one to it. A single interrupt line is raised while any status word that is enabled holds a set bit. Writing the configuration word with its top bit set clears the block back to its idle state. Channel counts are parameters, and the per-channel windows sit at fixed register numbers, each sized to its count.

Top module: `dmacr_regbank`

## Requirements
- R1: After hardware reset, configuration reads 0x0007C000, and every other register, the read data and the interrupt output are zero.
- R2: A write to configuration (0x180) with bit 31 set clears these registers: error status, interrupt enable, all four activation words and all four event status words. Table pointers and buffer sizes keep their values.
- R3: Configuration stores the written value ANDed with 0x00FFC087, so bit 31 always reads back as zero.
- R4: Interrupt enable (0x182) keeps bits 4:0. TX activation set/reset (0x184/0x185) keep bits 31:28, RX activation set/reset (0x190/0x191) keep bits 31:30, and buffer sizes keep bits 7:0.
- R5: Error status (0x181), TX end-of-buffer (0x186), TX descriptor error (0x187), RX end-of-buffer (0x192) and RX descriptor error (0x193) clear each bit written as one and keep each bit written as zero.
- R6: A pulse on channel i of an end-of-buffer or descriptor-error input sets bit 31-i of the matching status word. Bit k of the error flag input sets bit k of error status.
- R7: An event and a clearing write to the same bit in the same cycle leave the bit set. An event in the same cycle as a clearing configuration write also leaves its bit set.
- R8: Transmit table pointers are at 0x1A0+i and receive table pointers at 0x1C0+i, each holding 32 bits. Receive buffer sizes are at 0x1E0+i. Each window has one slot for each configured channel.
- R9: Unmapped register numbers, and window slots at or beyond the channel count, read as zero, and writes to them change nothing.
- R10: Read data is registered. It is updated only on the clock edge that samples the read strobe and holds at all other times. A read in the same cycle as a write to the same register returns the value before the write.
- R11: The interrupt output is high when, for any k, enable bit k is set and source k is nonzero. The sources are: k=0 error status, k=1 TX end-of-buffer, k=2 RX end-of-buffer, k=3 TX descriptor error, k=4 RX descriptor error.
- R12: The transmit and receive channel counts must each be between 1 and 32, and this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Register number |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| tx_eob_evt | input | TX_CH | Transmit end-of-buffer pulses |
| tx_derr_evt | input | TX_CH | Transmit descriptor error pulses |
| rx_eob_evt | input | RX_CH | Receive end-of-buffer pulses |
| rx_derr_evt | input | RX_CH | Receive descriptor error pulses |
| err_evt | input | 32 | Error flag pulses |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. Configuration never holds a bit outside its mask, and interrupt enable never holds a bit above 4. A clearing write to the transmit end-of-buffer word removes the written bits, and a channel 0 event always leaves its bit set. A soft reset empties interrupt enable, and read data stays stable without a strobe. The bench scenarios are needed for the rest. These cover the exact field masks of each register, the slots beyond the channel counts and unmapped numbers, and the bit placement of each event. They also cover the interrupt gating for each source, the read-during-write ordering, and the survival of pointers and sizes across a soft reset.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
   localparam int unsigned RA_W = 10;
   localparam int unsigned DW   = 32;

   // register numbers; neighbouring software decodes these
   localparam logic [RA_W-1:0] A_CFG   = 10'h180;
   localparam logic [RA_W-1:0] A_ESR   = 10'h181;
   localparam logic [RA_W-1:0] A_IEN   = 10'h182;
   localparam logic [RA_W-1:0] A_TXSET = 10'h184;
   localparam logic [RA_W-1:0] A_TXRST = 10'h185;
   localparam logic [RA_W-1:0] A_TXEOB = 10'h186;
   localparam logic [RA_W-1:0] A_TXDER = 10'h187;
   localparam logic [RA_W-1:0] A_RXSET = 10'h190;
   localparam logic [RA_W-1:0] A_RXRST = 10'h191;
   localparam logic [RA_W-1:0] A_RXEOB = 10'h192;
   localparam logic [RA_W-1:0] A_RXDER = 10'h193;
   localparam logic [RA_W-1:0] A_TXPTR = 10'h1A0;
   localparam logic [RA_W-1:0] A_RXPTR = 10'h1C0;
   localparam logic [RA_W-1:0] A_RXBSZ = 10'h1E0;

   localparam logic [DW-1:0] CFG_RST = 32'h0007_C000;
   localparam logic [DW-1:0] M_CFG   = 32'h00FF_C087;
   localparam logic [DW-1:0] M_IEN   = 32'h0000_001F;
   localparam logic [DW-1:0] M_TXACT = 32'hF000_0000;
   localparam logic [DW-1:0] M_RXACT = 32'hC000_0000;
   localparam logic [DW-1:0] M_BSZ   = 32'h0000_00FF;
   localparam logic [DW-1:0] M_PTR   = 32'hFFFF_FFFF;

   // interrupt source positions in the enable word
   typedef enum logic [2:0] {
      IRQ_ESR   = 3'd0,
      IRQ_TXEOB = 3'd1,
      IRQ_RXEOB = 3'd2,
      IRQ_TXDER = 3'd3,
      IRQ_RXDER = 3'd4
   } irq_src_e;
   localparam int unsigned N_IRQ = 5;
endpackage

// File: rtl/dmacr_w1c_reg.sv
// Sticky status word: events set bits, written ones clear them, events win.
module dmacr_w1c_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         clr_en,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] set_mask,
   output logic [W-1:0] q
);
   logic [W-1:0] kept;

   always_comb begin
      kept = soft_clr ? '0 : q;
      if (clr_en) kept = kept & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= kept | set_mask;
   end
endmodule

// File: rtl/dmacr_evt_spread.sv
// Places channel i's pulse at bit (W-1-i) of a status-sized word.
module dmacr_evt_spread #(
   parameter int unsigned N = 4,
   parameter int unsigned W = 32
) (
   input  logic [N-1:0] evt,
   output logic [W-1:0] vec
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < N) begin : g_used
         assign vec[W-1-i] = evt[i];
      end else begin : g_zero
         assign vec[W-1-i] = 1'b0;
      end
   end
endmodule

// File: rtl/dmacr_win.sv
// Window of N per-channel registers at BASE .. BASE+N-1.
module dmacr_win #(
   parameter int unsigned N     = 4,
   parameter int unsigned RA_W  = 10,
   parameter int unsigned W     = 32,
   parameter logic [RA_W-1:0] BASE = '0,
   parameter logic [W-1:0]    MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] addr,
   input  logic            wr,
   input  logic [W-1:0]    wdata,
   output logic [W-1:0]    rd_val
);
   logic [W-1:0] slot_q [N];

   for (genvar i = 0; i < N; i++) begin : g_slot
      localparam logic [RA_W-1:0] SLOT_A = BASE + RA_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    slot_q[i] <= '0;
         else if (wr && addr == SLOT_A) slot_q[i] <= wdata & MASK;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N; i++) begin
         if (addr == BASE + RA_W'(i)) rd_val = slot_q[i];
      end
   end
endmodule

// File: rtl/dmacr_regbank.sv
module dmacr_regbank
   import dmacr_pkg::*;
#(
   parameter int unsigned TX_CH = 4,
   parameter int unsigned RX_CH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RA_W-1:0]  reg_addr,
   input  logic             reg_wr,
   input  logic [DW-1:0]    reg_wdata,
   input  logic             reg_rd,
   output logic [DW-1:0]    reg_rdata,
   input  logic [TX_CH-1:0] tx_eob_evt,
   input  logic [TX_CH-1:0] tx_derr_evt,
   input  logic [RX_CH-1:0] rx_eob_evt,
   input  logic [RX_CH-1:0] rx_derr_evt,
   input  logic [DW-1:0]    err_evt,
   output logic             irq
);
   localparam int unsigned MAX_CH = 32;

   // R12: channel counts bounded at elaboration
   if (TX_CH < 1 || TX_CH > MAX_CH) begin : g_bad_tx
      $error("dmacr_regbank: TX_CH must be 1..32");
   end
   if (RX_CH < 1 || RX_CH > MAX_CH) begin : g_bad_rx
      $error("dmacr_regbank: RX_CH must be 1..32");
   end

   logic soft_rst;
   assign soft_rst = reg_wr && reg_addr == A_CFG && reg_wdata[DW-1];

   // plain masked registers
   logic [DW-1:0] cfg_q, ier_q, txset_q, txrst_q, rxset_q, rxrst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= CFG_RST;
         ier_q   <= '0;
         txset_q <= '0;
         txrst_q <= '0;
         rxset_q <= '0;
         rxrst_q <= '0;
      end else begin
         if (soft_rst) begin
            ier_q   <= '0;
            txset_q <= '0;
            txrst_q <= '0;
            rxset_q <= '0;
            rxrst_q <= '0;
         end
         if (reg_wr) begin
            unique case (reg_addr)
               A_CFG:   cfg_q   <= reg_wdata & M_CFG;
               A_IEN:   ier_q   <= reg_wdata & M_IEN;
               A_TXSET: txset_q <= reg_wdata & M_TXACT;
               A_TXRST: txrst_q <= reg_wdata & M_TXACT;
               A_RXSET: rxset_q <= reg_wdata & M_RXACT;
               A_RXRST: rxrst_q <= reg_wdata & M_RXACT;
               default: ;
            endcase
         end
      end
   end

   // sticky status words
   logic [DW-1:0] txeob_set, txder_set, rxeob_set, rxder_set;
   logic [DW-1:0] esr_q, txeob_q, txder_q, rxeob_q, rxder_q;

   dmacr_evt_spread #(.N(TX_CH), .W(DW)) u_sp_txeob (.evt(tx_eob_evt),  .vec(txeob_set));
   dmacr_evt_spread #(.N(TX_CH), .W(DW)) u_sp_txder (.evt(tx_derr_evt), .vec(txder_set));
   dmacr_evt_spread #(.N(RX_CH), .W(DW)) u_sp_rxeob (.evt(rx_eob_evt),  .vec(rxeob_set));
   dmacr_evt_spread #(.N(RX_CH), .W(DW)) u_sp_rxder (.evt(rx_derr_evt), .vec(rxder_set));

   dmacr_w1c_reg #(.W(DW)) u_esr (.clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .clr_en(reg_wr && reg_addr == A_ESR), .clr_mask(reg_wdata), .set_mask(err_evt), .q(esr_q));
   dmacr_w1c_reg #(.W(DW)) u_txeob (.clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .clr_en(reg_wr && reg_addr == A_TXEOB), .clr_mask(reg_wdata), .set_mask(txeob_set), .q(txeob_q));
   dmacr_w1c_reg #(.W(DW)) u_txder (.clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .clr_en(reg_wr && reg_addr == A_TXDER), .clr_mask(reg_wdata), .set_mask(txder_set), .q(txder_q));
   dmacr_w1c_reg #(.W(DW)) u_rxeob (.clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .clr_en(reg_wr && reg_addr == A_RXEOB), .clr_mask(reg_wdata), .set_mask(rxeob_set), .q(rxeob_q));
   dmacr_w1c_reg #(.W(DW)) u_rxder (.clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
      .clr_en(reg_wr && reg_addr == A_RXDER), .clr_mask(reg_wdata), .set_mask(rxder_set), .q(rxder_q));

   // per-channel windows (untouched by soft reset)
   logic [DW-1:0] txptr_rd, rxptr_rd, rxbsz_rd;

   dmacr_win #(.N(TX_CH), .RA_W(RA_W), .W(DW), .BASE(A_TXPTR), .MASK(M_PTR)) u_txptr (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .rd_val(txptr_rd));
   dmacr_win #(.N(RX_CH), .RA_W(RA_W), .W(DW), .BASE(A_RXPTR), .MASK(M_PTR)) u_rxptr (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .rd_val(rxptr_rd));
   dmacr_win #(.N(RX_CH), .RA_W(RA_W), .W(DW), .BASE(A_RXBSZ), .MASK(M_BSZ)) u_rxbsz (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .rd_val(rxbsz_rd));

   // read path
   logic [DW-1:0] fixed_rd;

   always_comb begin
      unique case (reg_addr)
         A_CFG:   fixed_rd = cfg_q;
         A_ESR:   fixed_rd = esr_q;
         A_IEN:   fixed_rd = ier_q;
         A_TXSET: fixed_rd = txset_q;
         A_TXRST: fixed_rd = txrst_q;
         A_TXEOB: fixed_rd = txeob_q;
         A_TXDER: fixed_rd = txder_q;
         A_RXSET: fixed_rd = rxset_q;
         A_RXRST: fixed_rd = rxrst_q;
         A_RXEOB: fixed_rd = rxeob_q;
         A_RXDER: fixed_rd = rxder_q;
         default: fixed_rd = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= fixed_rd | txptr_rd | rxptr_rd | rxbsz_rd;
   end

   // interrupt combine
   logic [N_IRQ-1:0] src_nz;
   assign src_nz[IRQ_ESR]   = |esr_q;
   assign src_nz[IRQ_TXEOB] = |txeob_q;
   assign src_nz[IRQ_RXEOB] = |rxeob_q;
   assign src_nz[IRQ_TXDER] = |txder_q;
   assign src_nz[IRQ_RXDER] = |rxder_q;
   assign irq = |(src_nz & ier_q[N_IRQ-1:0]);
endmodule

// File: rtl/dmacr_regbank_chk.sv
module dmacr_regbank_chk
   import dmacr_pkg::*;
#(
   parameter int unsigned TX_CH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [RA_W-1:0]  reg_addr,
   input logic             reg_wr,
   input logic [DW-1:0]    reg_wdata,
   input logic             reg_rd,
   input logic [DW-1:0]    reg_rdata,
   input logic [TX_CH-1:0] tx_eob_evt,
   input logic [DW-1:0]    cfg_q,
   input logic [DW-1:0]    ier_q,
   input logic [DW-1:0]    txeob_q
);
   a_r3_cfg_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~M_CFG) == '0);

   a_r4_ien_width: assert property (@(posedge clk) disable iff (!rst_n)
      ier_q[DW-1:N_IRQ] == '0);

   a_r5_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TXEOB && tx_eob_evt == '0)
      |=> ((txeob_q & $past(reg_wdata)) == '0));

   a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tx_eob_evt[0] |=> txeob_q[DW-1]);

   a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CFG && reg_wdata[DW-1]) |=> (ier_q == '0));

   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

bind dmacr_regbank dmacr_regbank_chk #(.TX_CH(TX_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
   .tx_eob_evt(tx_eob_evt), .cfg_q(cfg_q), .ier_q(ier_q), .txeob_q(txeob_q));

// File: tb/dmacr_regbank_bench.sv
module dmacr_regbank_bench;
   localparam int TX = 4;
   localparam int RX = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [9:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_rd = 1'b0;
   logic [31:0]   reg_rdata;
   logic [TX-1:0] tx_eob_evt = '0;
   logic [TX-1:0] tx_derr_evt = '0;
   logic [RX-1:0] rx_eob_evt = '0;
   logic [RX-1:0] rx_derr_evt = '0;
   logic [31:0]   err_evt = '0;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dmacr_regbank #(.TX_CH(TX), .RX_CH(RX)) u_dmacr_regbank (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt),
      .rx_eob_evt(rx_eob_evt), .rx_derr_evt(rx_derr_evt),
      .err_evt(err_evt), .irq(irq));

   typedef struct packed {
      logic [9:0]  a;
      logic [31:0] w;
      logic [31:0] e;
      logic [7:0]  r;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{10'h182, 32'hFFFF_FFFF, 32'h0000_001F, 8'd4},  // R4 enable width
      '{10'h184, 32'hFFFF_FFFF, 32'hF000_0000, 8'd4},  // R4 tx set
      '{10'h185, 32'h1234_5678, 32'h1000_0000, 8'd4},  // R4 tx reset
      '{10'h190, 32'hFFFF_FFFF, 32'hC000_0000, 8'd4},  // R4 rx set
      '{10'h191, 32'h7FFF_FFFF, 32'h4000_0000, 8'd4},  // R4 rx reset
      '{10'h1A0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd8},  // R8 tx ptr 0
      '{10'h1A3, 32'h0123_4567, 32'h0123_4567, 8'd8},  // R8 last tx ptr
      '{10'h1A4, 32'hFFFF_FFFF, 32'h0000_0000, 8'd9},  // R9 beyond tx count
      '{10'h1C1, 32'hCAFE_F00D, 32'hCAFE_F00D, 8'd8},  // R8 rx ptr 1
      '{10'h1C2, 32'hFFFF_FFFF, 32'h0000_0000, 8'd9},  // R9 beyond rx count
      '{10'h1E0, 32'hFFFF_FF5A, 32'h0000_005A, 8'd4},  // R4 buffer size
      '{10'h1E1, 32'h0000_01A5, 32'h0000_00A5, 8'd4},  // R4 buffer size
      '{10'h1E2, 32'h0000_0001, 32'h0000_0000, 8'd9},  // R9 beyond size count
      '{10'h183, 32'hFFFF_FFFF, 32'h0000_0000, 8'd9},  // R9 unmapped
      '{10'h180, 32'h7FFF_FFFF, 32'h00FF_C087, 8'd3}   // R3 cfg mask
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", reg_rdata, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      rd(10'h180, v); check("R1 cfg", v, 32'h0007_C000);
      rd(10'h182, v); check("R1 ien", v, 32'h0);
      rd(10'h186, v); check("R1 txeob", v, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         wr(TBL[i].a, TBL[i].w);
         rd(TBL[i].a, v);
         check($sformatf("R%0d table %0d", TBL[i].r, i), v, TBL[i].e);
      end
      rd(10'h1A0, v); check("R9 slot 0 untouched", v, 32'hDEAD_BEEF);

      // R6 event placement
      @(negedge clk); tx_eob_evt = 4'b0010;
      @(negedge clk); tx_eob_evt = '0;
      rd(10'h186, v); check("R6 tx eob ch1", v, 32'h4000_0000);
      check("R11 irq all enabled", {31'h0, irq}, 32'h1);
      wr(10'h182, 32'h4);
      check("R11 irq rx eob only", {31'h0, irq}, 32'h0);
      wr(10'h182, 32'h2);
      check("R11 irq tx eob only", {31'h0, irq}, 32'h1);
      @(negedge clk); rx_derr_evt = 2'b01;
      @(negedge clk); rx_derr_evt = '0;
      rd(10'h193, v); check("R6 rx derr ch0", v, 32'h8000_0000);
      @(negedge clk); err_evt = 32'h11;
      @(negedge clk); err_evt = '0;
      rd(10'h181, v); check("R6 err flags", v, 32'h11);

      // R5 write-one-to-clear
      wr(10'h181, 32'h01);
      rd(10'h181, v); check("R5 partial clear", v, 32'h10);
      wr(10'h186, 32'h4000_0000);
      rd(10'h186, v); check("R5 full clear", v, 32'h0);
      check("R11 irq source cleared", {31'h0, irq}, 32'h0);

      // R7 event beats clear in the same cycle
      @(negedge clk);
      reg_addr = 10'h186; reg_wdata = 32'h8000_0000; reg_wr = 1'b1; tx_eob_evt = 4'b0001;
      @(negedge clk);
      reg_wr = 1'b0; tx_eob_evt = '0;
      rd(10'h186, v); check("R7 event wins", v, 32'h8000_0000);

      // R10 read during write returns old value, then holds
      @(negedge clk);
      reg_addr = 10'h182; reg_wdata = 32'h1F; reg_wr = 1'b1; reg_rd = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
      check("R10 read before write", reg_rdata, 32'h2);
      rd(10'h182, v); check("R10 new value", v, 32'h1F);
      wr(10'h182, 32'h0);
      repeat (3) @(negedge clk);
      check("R10 rdata holds", reg_rdata, 32'h1F);

      // R2 soft reset
      wr(10'h182, 32'h1F);
      wr(10'h180, 32'h8000_0003);
      rd(10'h180, v); check("R2 cfg after soft reset", v, 32'h3);
      rd(10'h182, v); check("R2 ien cleared", v, 32'h0);
      rd(10'h186, v); check("R2 txeob cleared", v, 32'h0);
      rd(10'h193, v); check("R2 rxder cleared", v, 32'h0);
      rd(10'h184, v); check("R2 tx set cleared", v, 32'h0);
      rd(10'h1A0, v); check("R2 ptr kept", v, 32'hDEAD_BEEF);
      rd(10'h1E0, v); check("R2 size kept", v, 32'h5A);
      check("R2 irq low", {31'h0, irq}, 32'h0);
      // R12 counts: default 4/2 windows end exactly at slots checked above
      summary();
   end
endmodule